// File: doc/BRIEF.md
# Low-Power Mode and Reset Qualification Controller

This block governs the sleep states of a small microcontroller core. Software raises a one-cycle request to enter a light sleep, in which only the instruction-executing core is clock-gated, or a deep sleep, in which the oscillator is shut off as well. In light sleep the peripheral clock, the timers, the serial logic and the interrupt logic keep running. Any enabled interrupt ends light sleep. Deep sleep can be left only through the external reset pin. Storage contents are untouched in both states, but the internal reset that ends deep sleep reinitialises the register file held by the core.

The block also qualifies the external reset pin. The internal reset is asserted only after the pin has been sampled high on 24 consecutive oscillator cycles, which is two machine cycles of 12 oscillator periods each. When the pin ends light sleep, the core resumes at once and runs until the qualified reset arrives. For that window the block raises a storage-write block signal, while port writes stay allowed. The block also drives override controls for the external address-latch and code-fetch strobes, and a float control for the multiplexed low address/data port while code is fetched from external memory.

Top module: `lpc_top`

## Requirements
- R1: After a qualified internal reset, the block is in run mode: cpuClkEn=1, periphClkEn=1, oscEn=1, strobeOvr=0, port0Float=0, ramWrBlock=0.
- R2: intReset rises on the clock edge at which rstPin has been sampled high for the 24th consecutive time. It stays high while rstPin stays high and falls on the first edge that samples rstPin low. A high pulse shorter than 24 samples causes no internal reset.
- R3: After an idle request in run mode, the next edge gives cpuClkEn=0 with periphClkEn=1 and oscEn=1.
- R4: In idle, an intWake sampled high returns the block to run mode (cpuClkEn=1) on that edge.
- R5: strobeOvr=1 means the strobes are forced to the level on strobeLvl. Idle gives strobeOvr=1 and strobeLvl=1. Power-down gives strobeOvr=1 and strobeLvl=0. Run mode gives strobeOvr=0.
- R6: After a power-down request, the next edge gives cpuClkEn=0, periphClkEn=0 and oscEn=0. intWake is ignored in power-down. Only the qualified reset returns to run mode, on the edge after intReset rises, and oscEn follows rstPin high at once so that the qualifier can count.
- R7: port0Float=1 exactly when the block is in idle or power-down and extCode=1.
- R8: If idleReq and pdReq are both high on the same run-mode edge, the block enters power-down.
- R9: If rstPin is sampled high in idle, the next edge gives cpuClkEn=1 and ramWrBlock=1. ramWrBlock stays high until the edge after intReset rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| supplyOk | input | 1 | Supply-good indication, low clears state asynchronously |
| rstPin | input | 1 | External reset pin, active high |
| idleReq | input | 1 | Software request for idle, one cycle |
| pdReq | input | 1 | Software request for power-down, one cycle |
| intWake | input | 1 | An enabled interrupt is pending |
| extCode | input | 1 | Code is being fetched from external memory |
| intReset | output | 1 | Qualified internal reset |
| cpuClkEn | output | 1 | Core clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| strobeOvr | output | 1 | Force the external strobes |
| strobeLvl | output | 1 | Level of the forced strobes |
| port0Float | output | 1 | Release the multiplexed low port |
| ramWrBlock | output | 1 | Inhibit internal storage writes |

## Verification
The assertions assume that clk keeps toggling in power-down, which models an oscillator that restarts at once when oscEn returns. They also assume that supplyOk stays high after power-up, and that the sleep requests are sampled only as one-cycle pulses. The bench drives every input just after a falling edge and holds supplyOk high after the first cycles. It keeps the clock free-running throughout, so the reset qualifier can count while the block is in power-down.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } modeT;

  typedef struct packed {
    logic idleOn;
    logic pdOn;
    logic pinWake;
  } modeStrobeT;
endpackage

// File: rtl/lpc_mode_ctrl.sv
module lpc_mode_ctrl
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       supplyOk,
  input  logic       intReset,
  input  logic       rstPin,
  input  logic       idleReq,
  input  logic       pdReq,
  input  logic       intWake,
  output modeStrobeT strb
);
  modeT mode, modeNext;

  always_comb begin
    modeNext = mode;
    if (intReset) begin
      modeNext = MODE_RUN;
    end else begin
      unique case (mode)
        MODE_RUN: begin
          if (pdReq)        modeNext = MODE_PDOWN;
          else if (idleReq) modeNext = MODE_IDLE;
        end
        MODE_IDLE: begin
          if (intWake || rstPin) modeNext = MODE_RUN;
        end
        MODE_PDOWN: modeNext = MODE_PDOWN;
        default:    modeNext = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) mode <= MODE_RUN;
    else           mode <= modeNext;
  end

  always_comb begin
    strb.idleOn  = (mode == MODE_IDLE);
    strb.pdOn    = (mode == MODE_PDOWN);
    strb.pinWake = (mode == MODE_IDLE) && rstPin && !intReset;
  end

  AST_PD_STICKY: assert property (@(posedge clk) disable iff (!supplyOk)
    (strb.pdOn && !intReset) |=> strb.pdOn); // R6
  AST_PD_PRIORITY: assert property (@(posedge clk) disable iff (!supplyOk)
    (!strb.idleOn && !strb.pdOn && pdReq && idleReq && !intReset) |=> strb.pdOn); // R8
  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!supplyOk)
    (strb.idleOn && intWake && !intReset) |=> (!strb.idleOn && !strb.pdOn)); // R4
endmodule

// File: rtl/lpc_drive_path.sv
module lpc_drive_path
  import lpc_pkg::*;
#(
  parameter int OSC_PER_MC = 12,
  parameter int QUAL_MC    = 2
) (
  input  logic       clk,
  input  logic       supplyOk,
  input  logic       rstPin,
  input  logic       extCode,
  input  modeStrobeT strb,
  output logic       intReset,
  output logic       cpuClkEn,
  output logic       periphClkEn,
  output logic       oscEn,
  output logic       strobeOvr,
  output logic       strobeLvl,
  output logic       port0Float,
  output logic       ramWrBlock
);
  localparam int QUAL  = OSC_PER_MC * QUAL_MC;
  localparam int CNT_W = $clog2(QUAL + 1);
  localparam logic [CNT_W-1:0] QUAL_C = CNT_W'(QUAL);

  logic [CNT_W-1:0] highCnt;
  logic             wakeWin;

  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk)            highCnt <= '0;
    else if (!rstPin)         highCnt <= '0;
    else if (highCnt != QUAL_C) highCnt <= highCnt + 1'b1;
  end

  assign intReset = (highCnt == QUAL_C);

  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) wakeWin <= 1'b0;
    else           wakeWin <= strb.pinWake || (wakeWin && rstPin && !intReset);
  end

  logic asleep;
  assign asleep      = strb.idleOn || strb.pdOn;
  assign cpuClkEn    = !asleep;
  assign periphClkEn = !strb.pdOn;
  assign oscEn       = !strb.pdOn || rstPin;
  assign strobeOvr   = asleep;
  assign strobeLvl   = strb.idleOn;
  assign port0Float  = asleep && extCode;
  assign ramWrBlock  = wakeWin;

  AST_QUAL_PIN: assert property (@(posedge clk) disable iff (!supplyOk)
    intReset |-> $past(rstPin)); // R2
  AST_WIN_RUNS: assert property (@(posedge clk) disable iff (!supplyOk)
    ramWrBlock |-> cpuClkEn); // R9
  AST_PD_OSC: assert property (@(posedge clk) disable iff (!supplyOk)
    (strb.pdOn && !rstPin) |-> (!oscEn && !periphClkEn)); // R6
endmodule

// File: rtl/lpc_top.sv
module lpc_top
  import lpc_pkg::*;
#(
  parameter int OSC_PER_MC = 12,
  parameter int QUAL_MC    = 2
) (
  input  logic clk,
  input  logic supplyOk,
  input  logic rstPin,
  input  logic idleReq,
  input  logic pdReq,
  input  logic intWake,
  input  logic extCode,
  output logic intReset,
  output logic cpuClkEn,
  output logic periphClkEn,
  output logic oscEn,
  output logic strobeOvr,
  output logic strobeLvl,
  output logic port0Float,
  output logic ramWrBlock
);
  modeStrobeT strb;

  lpc_mode_ctrl i_ctrl (
    .clk(clk), .supplyOk(supplyOk), .intReset(intReset), .rstPin(rstPin),
    .idleReq(idleReq), .pdReq(pdReq), .intWake(intWake), .strb(strb)
  );

  lpc_drive_path #(.OSC_PER_MC(OSC_PER_MC), .QUAL_MC(QUAL_MC)) i_path (
    .clk(clk), .supplyOk(supplyOk), .rstPin(rstPin), .extCode(extCode),
    .strb(strb), .intReset(intReset), .cpuClkEn(cpuClkEn),
    .periphClkEn(periphClkEn), .oscEn(oscEn), .strobeOvr(strobeOvr),
    .strobeLvl(strobeLvl), .port0Float(port0Float), .ramWrBlock(ramWrBlock)
  );
endmodule

// File: tb/test_lpc_top.sv
module test_lpc_top;
  localparam int CLK_PERIOD = 10;
  localparam int QUAL = 24;

  logic clk = 1'b0;
  logic supplyOk = 1'b0, rstPin = 1'b0, idleReq = 1'b0, pdReq = 1'b0;
  logic intWake = 1'b0, extCode = 1'b0;
  logic intReset, cpuClkEn, periphClkEn, oscEn, strobeOvr, strobeLvl;
  logic port0Float, ramWrBlock;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpc_top i_lpc_top (
    .clk(clk), .supplyOk(supplyOk), .rstPin(rstPin), .idleReq(idleReq),
    .pdReq(pdReq), .intWake(intWake), .extCode(extCode), .intReset(intReset),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .oscEn(oscEn),
    .strobeOvr(strobeOvr), .strobeLvl(strobeLvl), .port0Float(port0Float),
    .ramWrBlock(ramWrBlock)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rstPin = 1'b1; cyc(QUAL + 1);
    rstPin = 1'b0; cyc(1);
  endtask

  task automatic pulse_req(input logic idl, input logic pd);
    idleReq = idl; pdReq = pd; cyc(1);
    idleReq = 1'b0; pdReq = 1'b0;
  endtask

  task automatic t_r1_reset_state();
    do_reset();
    chk("R1", "cpuClkEn", cpuClkEn, 1'b1);
    chk("R1", "periphClkEn", periphClkEn, 1'b1);
    chk("R1", "oscEn", oscEn, 1'b1);
    chk("R1", "strobeOvr", strobeOvr, 1'b0);
    chk("R1", "port0Float", port0Float, 1'b0);
    chk("R1", "ramWrBlock", ramWrBlock, 1'b0);
  endtask

  task automatic t_r2_qualify();
    rstPin = 1'b1; cyc(20);
    rstPin = 1'b0; cyc(1);
    chk("R2", "short pulse intReset", intReset, 1'b0);
    rstPin = 1'b1; cyc(QUAL - 1);
    chk("R2", "intReset after 23", intReset, 1'b0);
    cyc(1);
    chk("R2", "intReset after 24", intReset, 1'b1);
    cyc(5);
    chk("R2", "intReset held", intReset, 1'b1);
    rstPin = 1'b0; #1;
    chk("R2", "intReset before edge", intReset, 1'b1);
    cyc(1);
    chk("R2", "intReset released", intReset, 1'b0);
  endtask

  task automatic t_r3_r4_r5_idle();
    pulse_req(1'b1, 1'b0);
    chk("R3", "cpuClkEn idle", cpuClkEn, 1'b0);
    chk("R3", "periphClkEn idle", periphClkEn, 1'b1);
    chk("R3", "oscEn idle", oscEn, 1'b1);
    chk("R5", "strobeOvr idle", strobeOvr, 1'b1);
    chk("R5", "strobeLvl idle", strobeLvl, 1'b1);
    chk("R7", "port0Float idle internal", port0Float, 1'b0);
    extCode = 1'b1; #1;
    chk("R7", "port0Float idle external", port0Float, 1'b1);
    cyc(3);
    chk("R3", "idle persists", cpuClkEn, 1'b0);
    intWake = 1'b1; cyc(1); intWake = 1'b0;
    chk("R4", "cpuClkEn after wake", cpuClkEn, 1'b1);
    chk("R5", "strobeOvr run", strobeOvr, 1'b0);
    chk("R7", "port0Float run external", port0Float, 1'b0);
    extCode = 1'b0;
  endtask

  task automatic t_r6_pdown();
    extCode = 1'b1;
    pulse_req(1'b0, 1'b1);
    chk("R6", "cpuClkEn pd", cpuClkEn, 1'b0);
    chk("R6", "periphClkEn pd", periphClkEn, 1'b0);
    chk("R6", "oscEn pd", oscEn, 1'b0);
    chk("R5", "strobeOvr pd", strobeOvr, 1'b1);
    chk("R5", "strobeLvl pd", strobeLvl, 1'b0);
    chk("R7", "port0Float pd external", port0Float, 1'b1);
    extCode = 1'b0;
    intWake = 1'b1; cyc(3); intWake = 1'b0;
    chk("R6", "intWake ignored cpu", cpuClkEn, 1'b0);
    chk("R6", "intWake ignored osc", oscEn, 1'b0);
    rstPin = 1'b1; #1;
    chk("R6", "oscEn on reset pin", oscEn, 1'b1);
    cyc(QUAL);
    chk("R6", "intReset in pd", intReset, 1'b1);
    chk("R6", "still asleep at qualify", cpuClkEn, 1'b0);
    cyc(1);
    chk("R6", "run after reset", cpuClkEn, 1'b1);
    chk("R6", "periph after reset", periphClkEn, 1'b1);
    rstPin = 1'b0; cyc(1);
  endtask

  task automatic t_r8_priority();
    pulse_req(1'b1, 1'b1);
    chk("R8", "periphClkEn both req", periphClkEn, 1'b0);
    chk("R8", "strobeLvl both req", strobeLvl, 1'b0);
    do_reset();
    chk("R8", "recovered", cpuClkEn, 1'b1);
  endtask

  task automatic t_r9_pin_wake();
    pulse_req(1'b1, 1'b0);
    chk("R9", "in idle", cpuClkEn, 1'b0);
    chk("R9", "no block before", ramWrBlock, 1'b0);
    rstPin = 1'b1; cyc(1);
    chk("R9", "cpu resumes", cpuClkEn, 1'b1);
    chk("R9", "ramWrBlock set", ramWrBlock, 1'b1);
    cyc(QUAL - 1);
    chk("R9", "intReset at 24", intReset, 1'b1);
    chk("R9", "ramWrBlock held", ramWrBlock, 1'b1);
    cyc(1);
    chk("R9", "ramWrBlock cleared", ramWrBlock, 1'b0);
    rstPin = 1'b0; cyc(1);
  endtask

  initial begin
    cyc(2);
    supplyOk = 1'b1;
    cyc(2);
    t_r1_reset_state();
    t_r2_qualify();
    t_r3_r4_r5_idle();
    t_r6_pdown();
    t_r8_priority();
    t_r9_pin_wake();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    total++; bad++;
    $display("FAIL watchdog run did not end actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule